// File: doc/BRIEF.md
# Serial Autobaud Bit-Time Detector

This block sits on the receive wire of a UART whose rate is not known in advance. After reset it waits for a single calibration character, a lowercase 'f' (0x66), and measures how many system clock cycles one bit of that character lasts. The resulting count is presented as a baud divisor to the UART's receiver and transmitter, so the link works at whatever rate the far end chose and with whatever oscillator the chip happens to run from.

The character is sent least significant bit first, so 0x66 opens with a low stretch covering the start bit and data bit 0, two bit times in all. The detector times that first low stretch from its falling edge to the following rising edge, halves it with rounding and latches the result. Stretches that are implausibly short (noise) or long (a stuck or broken line) are thrown away and the detector waits for the next try. Once a divisor is latched the detector raises a lock level and a one-cycle lock pulse, stops looking at the line, and forwards the synchronized line level on its echo output so received characters can be returned to the sender. Only a reset starts a new calibration.

Top module: `autobaud_detect`

## Requirements
- R1: While reset is held and on the first cycle after it, `divisor` is 0, `locked` and `lock_pulse` are 0 and `echo_tx` is 1.
- R2: The low stretch length N is the number of clock cycles the synchronized line stays low, from the first falling edge seen while armed to the next rising edge; the latched divisor is (N+1)/2 rounded down, i.e. half of N rounded half up.
- R3: A stretch with MIN_RUN <= N <= MAX_RUN, both bounds inclusive, is accepted and locks the detector.
- R4: A stretch with N < MIN_RUN is rejected without locking, and the very next falling edge starts a fresh measurement.
- R5: A stretch with N > MAX_RUN is rejected without locking once its length passes MAX_RUN; the detector then waits for the line to return high before arming again, so the end of that stretch is never taken as a measurement.
- R6: If the line is low when reset is released, that low period is not measured; measurement only begins at a falling edge that follows a high level seen after reset.
- R7: `locked` rises and `lock_pulse` is high for exactly one cycle on the same clock edge; `locked` then stays high until reset.
- R8: After lock, further activity on `rx_in` changes neither `divisor` nor `locked` until reset.
- R9: Before lock `echo_tx` is held high whatever `rx_in` does; after lock `echo_tx` equals `rx_in` delayed by SYNC_STAGES clock edges.
- R10: With `rx_in` rising before clock edge k (edge k being the first to sample the high level) at the end of an accepted stretch, `locked` is first seen high after edge k+SYNC_STAGES and is still low after edge k+SYNC_STAGES-1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; every count is in cycles of this clock |
| rst_n | input | 1 | Synchronous reset, active low; starts a new calibration |
| rx_in | input | 1 | Asynchronous serial receive line, idle high |
| divisor | output | CNT_W | Clock cycles per bit; 0 until locked |
| locked | output | 1 | High once a valid divisor has been latched |
| lock_pulse | output | 1 | One-cycle strobe on the cycle `locked` rises |
| echo_tx | output | 1 | Synchronized receive level after lock, idle high before |

## Verification
The bench builds the detector with MIN_RUN of 8 and MAX_RUN of 600 and two synchronizer stages, which puts both acceptance bounds, the stretches one cycle beyond each, and a low stretch running past the saturation limit within a few hundred cycles each. With these values, random bit times of 4 to 300 cycles cover full 'f' frames across the whole accepted range, including odd stretch lengths that exercise the rounding. The default MAX_RUN of 65535 would make the upper rejection path cost tens of thousands of cycles per attempt.

// File: rtl/autobaud_pkg.sv
// Shared definitions for the autobaud detector.
// Assumes: nothing beyond IEEE 1800-2017.
package autobaud_pkg;

    // Calibration progress of the detector.
    //   ABD_ARM  : waiting to see the line high (ignores a line low at reset)
    //   ABD_IDLE : line high, waiting for the falling edge of the start bit
    //   ABD_MEAS : timing the first low stretch
    //   ABD_LOCK : divisor latched; line no longer examined
    typedef enum logic [1:0] {
        ABD_ARM  = 2'd0,
        ABD_IDLE = 2'd1,
        ABD_MEAS = 2'd2,
        ABD_LOCK = 2'd3
    } abd_state_e;

endpackage

// File: rtl/abd_line_sync.sv
// Brings the asynchronous receive line into the clock domain through a
// chain of STAGES flops and derives one-cycle edge flags from the
// synchronized level.
// Assumes: STAGES >= 2. The chain resets low, so a line that is already
// high at reset shows a rising edge, never a falling one.
module abd_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rx_in,
    output logic line_o,
    output logic fall_o,
    output logic rise_o
);

    logic [STAGES-1:0] chain;
    logic              line_prev;

    // Build the synchronizer chain one stage at a time.
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            // First stage samples the raw line.
            always_ff @(posedge clk) begin
                if (!rst_n) chain[0] <= 1'b0;
                else        chain[0] <= rx_in;
            end
        end else begin : g_next
            // Later stages shift the sample along.
            always_ff @(posedge clk) begin
                if (!rst_n) chain[s] <= 1'b0;
                else        chain[s] <= chain[s-1];
            end
        end
    end

    // Keep last cycle's synchronized level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) line_prev <= 1'b0;
        else        line_prev <= chain[STAGES-1];
    end

    // Present level and edge flags.
    always_comb begin
        line_o = chain[STAGES-1];
        fall_o = line_prev & ~chain[STAGES-1];
        rise_o = ~line_prev & chain[STAGES-1];
    end

endmodule

// File: rtl/abd_run_counter.sv
// Counts the length of a low stretch in clock cycles. A load sets the
// count to one (the first low cycle); each increment adds one. The count
// never passes LIMIT: at_limit tells the controller to give up.
// Assumes: the controller never asks for an increment while at_limit.
module abd_run_counter #(
    parameter int W     = 16,
    parameter int LIMIT = 65535
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic         inc,
    output logic [W-1:0] count,
    output logic         at_limit
);

    localparam logic [W-1:0] LIMIT_W = W'(LIMIT);
    localparam logic [W-1:0] ONE_W   = W'(1);

    // Load or advance the stretch length.
    always_ff @(posedge clk) begin
        if (!rst_n)                count <= '0;
        else if (load)             count <= ONE_W;
        else if (inc && !at_limit) count <= count + ONE_W;
    end

    // Flag the saturation point for the controller.
    always_comb at_limit = (count == LIMIT_W);

endmodule

// File: rtl/abd_lock_fsm.sv
// Calibration controller: arms on a high line, starts timing at the first
// falling edge, judges the stretch at the following rising edge and, if it
// falls inside [MIN_RUN, MAX_RUN], latches half of it (rounded half up) as
// the divisor and locks for good.
// Assumes: count/at_limit come from abd_run_counter driven by cnt_load and
// cnt_inc of this module; line/fall/rise come from abd_line_sync.
module abd_lock_fsm
    import autobaud_pkg::*;
#(
    parameter int W       = 16,
    parameter int MIN_RUN = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         line,
    input  logic         fall,
    input  logic         rise,
    input  logic [W-1:0] count,
    input  logic         at_limit,
    output logic         cnt_load,
    output logic         cnt_inc,
    output logic [W-1:0] divisor,
    output logic         locked,
    output logic         lock_pulse
);

    localparam logic [W-1:0] MIN_W = W'(MIN_RUN);

    abd_state_e   state, state_nx;
    logic         accept;
    logic [W:0]   half_up;

    // Judge the finished stretch and form its rounded half.
    always_comb begin
        accept  = rise && (count >= MIN_W);
        half_up = ({1'b0, count} + {{W{1'b0}}, 1'b1}) >> 1;
    end

    // Next state and counter commands.
    always_comb begin
        state_nx = state;
        cnt_load = 1'b0;
        cnt_inc  = 1'b0;
        case (state)
            ABD_ARM: begin
                if (line) state_nx = ABD_IDLE;
            end
            ABD_IDLE: begin
                if (fall) begin
                    state_nx = ABD_MEAS;
                    cnt_load = 1'b1;
                end
            end
            ABD_MEAS: begin
                if (rise) begin
                    state_nx = accept ? ABD_LOCK : ABD_IDLE;
                end else if (at_limit) begin
                    state_nx = ABD_ARM;
                end else begin
                    cnt_inc = 1'b1;
                end
            end
            default: state_nx = ABD_LOCK;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ABD_ARM;
        else        state <= state_nx;
    end

    // Latch the divisor and raise the lock outputs on acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            divisor    <= '0;
            locked     <= 1'b0;
            lock_pulse <= 1'b0;
        end else begin
            lock_pulse <= 1'b0;
            if (state == ABD_MEAS && accept) begin
                divisor    <= half_up[W-1:0];
                locked     <= 1'b1;
                lock_pulse <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/autobaud_detect.sv
// Autobaud detector top. Measures the opening low stretch (start bit plus
// bit 0) of a lowercase 'f' calibration character and presents the bit
// time as a divisor, then forwards the synchronized line for echo.
// Assumes: rx_in idles high; MIN_RUN >= 2 and MIN_RUN <= MAX_RUN;
// CNT_W is wide enough to hold MAX_RUN.
module autobaud_detect #(
    parameter int SYNC_STAGES = 2,
    parameter int MIN_RUN     = 16,
    parameter int MAX_RUN     = 65535,
    parameter int CNT_W       = $clog2(MAX_RUN + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rx_in,
    output logic [CNT_W-1:0] divisor,
    output logic             locked,
    output logic             lock_pulse,
    output logic             echo_tx
);

    logic             line, fall, rise;
    logic             cnt_load, cnt_inc, at_limit;
    logic [CNT_W-1:0] count;

    abd_line_sync #(
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .rx_in  (rx_in),
        .line_o (line),
        .fall_o (fall),
        .rise_o (rise)
    );

    abd_run_counter #(
        .W     (CNT_W),
        .LIMIT (MAX_RUN)
    ) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (cnt_load),
        .inc      (cnt_inc),
        .count    (count),
        .at_limit (at_limit)
    );

    abd_lock_fsm #(
        .W       (CNT_W),
        .MIN_RUN (MIN_RUN)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .line       (line),
        .fall       (fall),
        .rise       (rise),
        .count      (count),
        .at_limit   (at_limit),
        .cnt_load   (cnt_load),
        .cnt_inc    (cnt_inc),
        .divisor    (divisor),
        .locked     (locked),
        .lock_pulse (lock_pulse)
    );

    // Echo path: idle high until locked, then the synchronized line.
    always_comb echo_tx = locked ? line : 1'b1;

endmodule

// File: rtl/autobaud_detect_chk.sv
// Property checker for autobaud_detect, bound to every instance.
// Assumes: synchronous active-low reset on rst_n.
module autobaud_detect_chk #(
    parameter int MIN_RUN = 16,
    parameter int MAX_RUN = 65535,
    parameter int CNT_W   = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic [CNT_W-1:0] divisor,
    input logic             locked,
    input logic             lock_pulse,
    input logic             echo_tx
);

    localparam logic [CNT_W-1:0] DIV_LO = CNT_W'((MIN_RUN + 1) / 2);
    localparam logic [CNT_W-1:0] DIV_HI = CNT_W'((MAX_RUN + 1) / 2);

    // R1
    unlocked_div_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !locked |-> (divisor == '0));

    // R9
    unlocked_echo_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !locked |-> echo_tx);

    // R7
    lock_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        locked |=> locked);

    // R7
    pulse_on_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(locked) |-> lock_pulse);

    // R7
    pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lock_pulse |=> !lock_pulse);

    // R7
    pulse_with_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lock_pulse |-> locked);

    // R8
    div_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        locked |=> $stable(divisor));

    // R3
    div_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        locked |-> (divisor >= DIV_LO && divisor <= DIV_HI));

endmodule

bind autobaud_detect autobaud_detect_chk #(
    .MIN_RUN (MIN_RUN),
    .MAX_RUN (MAX_RUN),
    .CNT_W   (CNT_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .divisor    (divisor),
    .locked     (locked),
    .lock_pulse (lock_pulse),
    .echo_tx    (echo_tx)
);

// File: tb/autobaud_detect_test.sv
// Self-checking bench for autobaud_detect: directed corners plus random
// calibration frames with a fixed seed.
module autobaud_detect_test;

    localparam int SYNC = 2;
    localparam int MINR = 8;
    localparam int MAXR = 600;
    localparam int W    = $clog2(MAXR + 1);

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         rx_in = 1'b1;
    logic [W-1:0] divisor;
    logic         locked, lock_pulse, echo_tx;

    int n_tests = 0;
    int n_fail  = 0;

    autobaud_detect #(
        .SYNC_STAGES (SYNC),
        .MIN_RUN     (MINR),
        .MAX_RUN     (MAXR)
    ) uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .rx_in      (rx_in),
        .divisor    (divisor),
        .locked     (locked),
        .lock_pulse (lock_pulse),
        .echo_tx    (echo_tx)
    );

    // 125 MHz clock.
    always #4 clk = ~clk;

    // Expected divisor for a stretch of n cycles: half, rounded half up.
    function automatic int exp_div(input int n);
        return (n + 1) / 2;
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Hold a level for n cycles; starts and ends at a falling clock edge.
    task automatic drive(input logic lvl, input int n);
        rx_in = lvl;
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset(input logic lvl);
        @(negedge clk);
        rx_in = lvl;
        rst_n = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // One low stretch then enough high time for the decision to land.
    task automatic low_run(input int n);
        drive(1'b0, n);
        drive(1'b1, SYNC + 3);
    endtask

    // Full 0x66 frame, LSB first, first low stretch widened by extra.
    task automatic send_f(input int b, input int extra);
        drive(1'b0, 2 * b + extra);
        drive(1'b1, 2 * b);
        drive(1'b0, 2 * b);
        drive(1'b1, 2 * b);
        drive(1'b0, b);
        drive(1'b1, b + 10);
    endtask

    task automatic expect_lock(input int n, input string tag);
        chk(locked == 1'b1, {tag, " locked"}, int'(locked), 1);
        chk(int'(divisor) == exp_div(n), {tag, " divisor"}, int'(divisor), exp_div(n));
    endtask

    // Watchdog: a hung run is a failure and still prints the summary.
    initial begin
        repeat (190000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        int seed_v;
        seed_v = $urandom(32'h5eed);

        // R1: reset state
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk(divisor == '0 && !locked && !lock_pulse && echo_tx,
            "R1 in reset", int'(divisor), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(divisor == '0 && !locked && !lock_pulse && echo_tx,
            "R1 after reset", int'(locked), 0);

        // R10 / R7 / R2: exact lock latency on a 40-cycle stretch
        do_reset(1'b1);
        drive(1'b1, 5);
        drive(1'b0, 40);
        chk(echo_tx == 1'b1, "R9 echo idle before lock", int'(echo_tx), 1);
        rx_in = 1'b1;
        repeat (SYNC) @(negedge clk);
        chk(locked == 1'b0, "R10 not yet locked", int'(locked), 0);
        @(negedge clk);
        chk(locked && lock_pulse, "R10 lock edge", int'(locked), 1);
        chk(int'(divisor) == 20, "R2 divisor 40", int'(divisor), 20);
        @(negedge clk);
        chk(lock_pulse == 1'b0, "R7 pulse one cycle", int'(lock_pulse), 0);

        // R8: later line activity is ignored
        drive(1'b0, 10);
        drive(1'b1, 30);
        drive(1'b0, 300);
        drive(1'b1, 10);
        chk(locked && int'(divisor) == 20, "R8 divisor frozen", int'(divisor), 20);

        // R9: echo follows the line after SYNC edges
        rx_in = 1'b0;
        repeat (SYNC - 1) @(negedge clk);
        chk(echo_tx == 1'b1, "R9 echo before delay", int'(echo_tx), 1);
        @(negedge clk);
        chk(echo_tx == 1'b0, "R9 echo low", int'(echo_tx), 0);
        rx_in = 1'b1;
        repeat (SYNC) @(negedge clk);
        chk(echo_tx == 1'b1, "R9 echo high", int'(echo_tx), 1);

        // R4: too short, then next edge measured
        do_reset(1'b1);
        drive(1'b1, 5);
        low_run(MINR - 1);
        chk(locked == 1'b0, "R4 short rejected", int'(locked), 0);
        low_run(30);
        expect_lock(30, "R4 rearm");

        // R3: lower bound accepted
        do_reset(1'b1);
        drive(1'b1, 5);
        low_run(MINR);
        expect_lock(MINR, "R3 min bound");

        // R3: upper bound accepted
        do_reset(1'b1);
        drive(1'b1, 5);
        low_run(MAXR);
        expect_lock(MAXR, "R3 max bound");

        // R5: one past the bound, and a much longer stretch
        do_reset(1'b1);
        drive(1'b1, 5);
        low_run(MAXR + 1);
        chk(locked == 1'b0, "R5 max+1 rejected", int'(locked), 0);
        low_run(800);
        chk(locked == 1'b0, "R5 long rejected", int'(locked), 0);
        low_run(50);
        expect_lock(50, "R5 rearm");

        // R6: line low at reset release is not measured
        do_reset(1'b0);
        drive(1'b0, 50);
        drive(1'b1, SYNC + 5);
        chk(locked == 1'b0, "R6 reset-low ignored", int'(locked), 0);
        low_run(20);
        expect_lock(20, "R6 rearm");

        // R2: odd stretch rounds half up
        do_reset(1'b1);
        drive(1'b1, 5);
        low_run(41);
        expect_lock(41, "R2 odd round");

        // R2 / R3 / R4: random frames, some preceded by a short glitch
        for (int i = 0; i < 20; i++) begin
            int b, extra, glitch;
            b      = 4 + int'($urandom % 297);
            extra  = int'($urandom % 2);
            glitch = int'($urandom % 3);
            do_reset(1'b1);
            drive(1'b1, 3 + int'($urandom % 20));
            if (glitch != 0) begin
                low_run(1 + int'($urandom % (MINR - 1)));
            end
            if (2 * b + extra > MAXR) extra = 0;
            send_f(b, extra);
            expect_lock(2 * b + extra, "R2 random frame");
        end

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule